// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog with one 32-bit control and status register. Software selects a timeout from two 2-bit codes: a prescaler code that picks how many input ticks make one prescaled tick, and an interval code that picks how many prescaled ticks make up the timeout. When the timeout runs out, the block first raises an interrupt flag. It also drives an interrupt line if the interrupt enable bit is set. A fixed number of prescaled ticks later, if reset is enabled, the block sends a one-cycle system reset request and records that a watchdog reset took place.

Software keeps the timer alive by reading the register and writing the value back with the restart bit set. The layout is chosen so that this pattern keeps every control field unchanged. The status flags are write-1-to-clear, so the same write also acknowledges any flag that was set. Writing zero to the register stops the timer.

Top module: `wdt_twostage`

## Requirements
- R1: After power-on reset (`rst_n` low), `rd_data` is 0, `irq` is 0 and `rst_req` is 0.
- R2: Register bits 11:10 (prescaler code), 7 (enable), 6 (interrupt enable), 5:4 (interval code) and 1 (reset enable) read back as last written. Bit 0 (restart) and every bit outside 11:10 and 7:0 always read 0.
- R3: Prescaler codes 0..3 give ratios of 1, 2^PS1_LOG, 2^PS2_LOG and 2^PS3_LOG input ticks (defaults 8, 11, 16). Interval code k gives 2^(IVL_LOG+2k) prescaled ticks (IVL_LOG defaults to 14). While enabled, the interrupt flag (bit 3) becomes 1 on the clock edge that takes the ratio × interval-th tick after the count restarted.
- R4: `irq` equals the interrupt flag AND the interrupt enable bit.
- R5: 2^WARN_LOG prescaled ticks after the flag is set (WARN_LOG defaults to 10), one of two things happens. If reset enable is 1, `rst_req` is high for exactly one cycle, and the register then reads 0 except for bit 2 (reset flag) = 1. If reset enable is 0, no reset request is made and the timer stays enabled.
- R6: A write with bits 7 and 0 set restarts the prescaler and the interval count from zero and cancels a pending reset stage. If the restart write lands in the same cycle as the expiring tick, the restart wins and no flag is set.
- R7: A write that keeps enable at 1 but changes the prescaler or interval code restarts the count. A write that changes only the interrupt enable, the reset enable or the flags does not.
- R8: Writing 1 to bit 3 or bit 2 clears that flag, and writing 0 to it leaves it unchanged. If hardware sets the interrupt flag in the same cycle as a clear, the flag ends up 1.
- R9: The reset flag is not changed by writes that leave bit 2 at 0, and not by the watchdog firing. Only a 1 written to bit 2 or a power-on reset clears it.
- R10: Writing enable = 0 stops the timer. While stopped, the counts are held at zero and no flag or reset request is raised. Setting enable again later counts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset |
| tick | input | 1 | Timer tick strobe, one input tick per cycle it is high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read value |
| irq | output | 1 | Pre-timeout interrupt level |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
Two pairs of events can fall in the same cycle. The first is a software restart and the tick that ends the interval. The second is a write-1-to-clear of the interrupt flag and the hardware setting that flag. The bench walks the tick count to one short of the timeout, then issues the write with `tick` high in the same cycle. It judges the result from the flag bit read back on the next cycle: 0 after a restart, 1 after a clear. Random prescaler and interval codes, with random gaps between ticks, check the timeout against tick counts computed in the bench.

// File: rtl/wdt_ts_pkg.sv
package wdt_ts_pkg;

    localparam int REG_W = 32;

    // Bit positions of the control/status register
    localparam int B_RESTART = 0;
    localparam int B_RST_EN  = 1;
    localparam int B_RST_FLG = 2;
    localparam int B_IRQ_FLG = 3;
    localparam int B_IVL_LO  = 4;
    localparam int B_IRQ_EN  = 6;
    localparam int B_ENABLE  = 7;
    localparam int B_PRE_LO  = 10;

    typedef enum logic [1:0] {
        ST_COUNT = 2'd0,
        ST_WARN  = 2'd1,
        ST_DONE  = 2'd2
    } stage_e;

    typedef struct packed {
        logic [1:0] pre_sel;
        logic       enable;
        logic       irq_en;
        logic [1:0] ivl_sel;
        logic       rst_en;
        logic       irq_flag;
        logic       rst_flag;
        logic       rst_req;
    } ctl_t;

endpackage

// File: rtl/wdt_ts_prescale.sv
module wdt_ts_prescale #(
    parameter int PS1_LOG = 8,
    parameter int PS2_LOG = 11,
    parameter int PS3_LOG = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       clear,
    input  logic       tick,
    input  logic [1:0] sel,
    output logic       ptick
);
    localparam int PW = (PS3_LOG > 0) ? PS3_LOG : 1;

    function automatic logic [PW-1:0] ratio_lim(input logic [1:0] s);
        int sh;
        case (s)
            2'd0:    sh = 0;
            2'd1:    sh = PS1_LOG;
            2'd2:    sh = PS2_LOG;
            default: sh = PS3_LOG;
        endcase
        return PW'((64'd1 << sh) - 64'd1);
    endfunction

    logic [PW-1:0] pc_d, pc_q;
    logic          at_lim;

    always_comb begin
        pc_d   = pc_q;
        at_lim = (pc_q == ratio_lim(sel));
        ptick  = 1'b0;
        if (clear || !run) begin
            pc_d = '0;
        end else if (tick) begin
            if (at_lim) begin
                ptick = 1'b1;
                pc_d  = '0;
            end else begin
                pc_d = pc_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    // R3: a prescaled tick only comes from an input tick of a running timer
    assert_ptick_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ptick |-> (tick && run && !clear));

    // R10: a stopped timer holds the prescaler at zero
    assert_pre_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pc_q == '0));

endmodule

// File: rtl/wdt_ts_core.sv
module wdt_ts_core
    import wdt_ts_pkg::*;
#(
    parameter int IVL_LOG  = 14,
    parameter int WARN_LOG = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       clear,
    input  logic       ptick,
    input  logic [1:0] ivl_sel,
    input  logic       rst_en,
    output logic       expire,
    output logic       fire
);
    localparam int IMAX = IVL_LOG + 6;
    localparam int CW   = ((IMAX > WARN_LOG) ? IMAX : WARN_LOG) + 1;
    localparam logic [CW-1:0] WLIM = CW'((64'd1 << WARN_LOG) - 64'd1);

    typedef struct packed {
        stage_e        stage;
        logic [CW-1:0] cnt;
    } core_t;

    function automatic logic [CW-1:0] ivl_lim(input logic [1:0] s);
        return CW'((64'd1 << (IVL_LOG + 2 * int'(s))) - 64'd1);
    endfunction

    core_t q, d;

    always_comb begin
        d      = q;
        expire = 1'b0;
        fire   = 1'b0;
        if (clear || !run) begin
            d.stage = ST_COUNT;
            d.cnt   = '0;
        end else if (ptick) begin
            case (q.stage)
                ST_COUNT: begin
                    if (q.cnt == ivl_lim(ivl_sel)) begin
                        expire  = 1'b1;
                        d.stage = ST_WARN;
                        d.cnt   = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_WARN: begin
                    if (q.cnt == WLIM) begin
                        d.cnt = '0;
                        if (rst_en) begin
                            fire    = 1'b1;
                            d.stage = ST_COUNT;
                        end else begin
                            d.stage = ST_DONE;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: d = q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{stage: ST_COUNT, cnt: '0};
        else        q <= d;
    end

    // R5: the reset stage only fires from the warning window with reset enabled
    assert_fire_from_warn_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (q.stage == ST_WARN && rst_en && ptick));

    // R3: the interval end is only seen while counting
    assert_expire_from_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> (q.stage == ST_COUNT && run));

    // R6: a restart returns the stage machine to counting from zero
    assert_restart_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (q.stage == ST_COUNT && q.cnt == '0));

endmodule

// File: rtl/wdt_twostage.sv
module wdt_twostage
    import wdt_ts_pkg::*;
#(
    parameter int PS1_LOG  = 8,
    parameter int PS2_LOG  = 11,
    parameter int PS3_LOG  = 16,
    parameter int IVL_LOG  = 14,
    parameter int WARN_LOG = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        irq,
    output logic        rst_req
);
    ctl_t q, d;
    logic ptick, expire, fire, kill;

    // Any write that stops, restarts or re-times the count
    always_comb begin
        kill = wr_en && (!wr_data[B_ENABLE] || wr_data[B_RESTART] ||
               (q.enable && ((wr_data[B_PRE_LO+1:B_PRE_LO] != q.pre_sel) ||
                             (wr_data[B_IVL_LO+1:B_IVL_LO] != q.ivl_sel))));
    end

    wdt_ts_prescale #(
        .PS1_LOG(PS1_LOG),
        .PS2_LOG(PS2_LOG),
        .PS3_LOG(PS3_LOG)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (q.enable),
        .clear (kill),
        .tick  (tick),
        .sel   (q.pre_sel),
        .ptick (ptick)
    );

    wdt_ts_core #(
        .IVL_LOG (IVL_LOG),
        .WARN_LOG(WARN_LOG)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (q.enable),
        .clear   (kill),
        .ptick   (ptick),
        .ivl_sel (q.ivl_sel),
        .rst_en  (q.rst_en),
        .expire  (expire),
        .fire    (fire)
    );

    always_comb begin
        d         = q;
        d.rst_req = 1'b0;
        if (wr_en) begin
            d.pre_sel = wr_data[B_PRE_LO+1:B_PRE_LO];
            d.enable  = wr_data[B_ENABLE];
            d.irq_en  = wr_data[B_IRQ_EN];
            d.ivl_sel = wr_data[B_IVL_LO+1:B_IVL_LO];
            d.rst_en  = wr_data[B_RST_EN];
            if (wr_data[B_IRQ_FLG]) d.irq_flag = 1'b0;
            if (wr_data[B_RST_FLG]) d.rst_flag = 1'b0;
        end
        if (expire) d.irq_flag = 1'b1;
        if (fire) begin
            d          = '0;
            d.rst_flag = 1'b1;
            d.rst_req  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rd_data                        = '0;
        rd_data[B_PRE_LO+1:B_PRE_LO]   = q.pre_sel;
        rd_data[B_ENABLE]              = q.enable;
        rd_data[B_IRQ_EN]              = q.irq_en;
        rd_data[B_IVL_LO+1:B_IVL_LO]   = q.ivl_sel;
        rd_data[B_IRQ_FLG]             = q.irq_flag;
        rd_data[B_RST_FLG]             = q.rst_flag;
        rd_data[B_RST_EN]              = q.rst_en;
    end

    assign irq     = q.irq_flag & q.irq_en;
    assign rst_req = q.rst_req;

    // R5: the reset request lasts one cycle
    assert_req_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R5: a reset request comes with a stopped timer and a recorded reset
    assert_req_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (!q.enable && q.rst_flag && !q.irq_flag));

    // R5: a reset request needs reset enable set in the cycle before
    assert_req_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(q.rst_en && q.enable));

    // R8: a clear with no same-cycle set leaves the flag low
    assert_w1c_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[B_IRQ_FLG] && !expire) |=> !q.irq_flag);

    // R10: the flag only rises while the timer runs
    assert_flag_needs_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.irq_flag) |-> $past(q.enable));

    // R9: without a clear write or a power-on reset the reset flag never falls
    assert_rflag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rst_flag && !(wr_en && wr_data[B_RST_FLG])) |=> q.rst_flag);

endmodule

// File: tb/wdt_twostage_tb_top.sv
module wdt_twostage_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PS1 = 2, PS2 = 3, PS3 = 5, IVL = 2, WRN = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq, rst_req;

    int checks = 0;
    int errors = 0;
    int rst_seen = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wdt_twostage #(
        .PS1_LOG(PS1), .PS2_LOG(PS2), .PS3_LOG(PS3),
        .IVL_LOG(IVL), .WARN_LOG(WRN)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .rst_req(rst_req)
    );

    always @(posedge clk) if (rst_req) rst_seen++;

    function automatic int pdiv(input int ps);
        case (ps)
            0: return 1;
            1: return 1 << PS1;
            2: return 1 << PS2;
            default: return 1 << PS3;
        endcase
    endfunction

    function automatic int tout(input int ps, input int is);
        return pdiv(ps) * (1 << (IVL + 2 * is));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_t(input logic [31:0] v, input logic t);
        wr_en = 1'b1; wr_data = v; tick = t;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic wr(input logic [31:0] v);
        wr_t(v, 1'b0);
    endtask

    task automatic give_ticks(input int n);
        int k = 0;
        while (k < n) begin
            logic t = ($urandom_range(3) != 0);
            tick = t;
            @(negedge clk);
            if (t) k++;
        end
        tick = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int base;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 rd_data", rd_data, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 rst_req", {31'b0, rst_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: readback masks restart and unused bits
        wr(32'hFFFF_FFF3);
        chk("R2 readback all ones", rd_data, 32'h0000_0CF2);
        wr(32'h0);
        chk("R2 stop readback", rd_data, 32'h0);

        // R3/R4: random codes with random tick gaps
        for (int i = 0; i < 6; i++) begin
            int ps = $urandom_range(3);
            int is = $urandom_range(3);
            int ie = $urandom_range(1);
            int t  = tout(ps, is);
            logic [31:0] cfg = (ps << 10) | 32'h89 | (ie << 6) | (is << 4);
            wr(cfg);
            chk("R2 random readback", rd_data, cfg & 32'h0000_0CF2);
            give_ticks(t - 1);
            chk("R3 flag before timeout", {31'b0, rd_data[3]}, 32'h0);
            give_ticks(1);
            chk("R3 flag at timeout", {31'b0, rd_data[3]}, 32'h1);
            chk("R4 irq level", {31'b0, irq}, ie);
            wr(32'h0);
        end

        // R5: warning window then reset with reset enabled, interrupt off
        base = rst_seen;
        wr(32'h8B);
        give_ticks(3);
        chk("R3 flag early", {31'b0, rd_data[3]}, 32'h0);
        give_ticks(1);
        chk("R3 flag set", {31'b0, rd_data[3]}, 32'h1);
        chk("R4 irq masked", {31'b0, irq}, 32'h0);
        give_ticks(3);
        chk("R5 no request early", {31'b0, rst_req}, 32'h0);
        give_ticks(1);
        chk("R5 request high", {31'b0, rst_req}, 32'h1);
        chk("R5 register after fire", rd_data, 32'h4);
        @(negedge clk);
        chk("R5 request one cycle", {31'b0, rst_req}, 32'h0);
        chk("R5 request count", rst_seen - base, 1);
        wr(32'h83);
        chk("R9 reset flag kept", {31'b0, rd_data[2]}, 32'h1);
        wr(32'h04);
        chk("R9 reset flag cleared by write", rd_data, 32'h0);

        // R6: restart inside the warning window cancels the reset
        base = rst_seen;
        wr(32'hCB);
        give_ticks(4);
        give_ticks(2);
        wr(rd_data | 32'h1);
        chk("R8 ping clears flag", {31'b0, rd_data[3]}, 32'h0);
        give_ticks(3);
        chk("R6 no request after ping", rst_seen - base, 0);
        chk("R6 flag not yet", {31'b0, rd_data[3]}, 32'h0);
        give_ticks(1);
        chk("R6 new interval from zero", {31'b0, rd_data[3]}, 32'h1);
        wr(32'h0C);

        // R5: no reset when reset enable is 0
        base = rst_seen;
        wr(32'hC1);
        give_ticks(20);
        chk("R5 no request without enable", rst_seen - base, 0);
        chk("R5 still enabled", {31'b0, rd_data[7]}, 32'h1);

        // R6: restart in the same cycle as the expiring tick
        wr(32'hC9);
        give_ticks(3);
        wr_t(32'hC1, 1'b1);
        chk("R6 restart wins", {31'b0, rd_data[3]}, 32'h0);
        give_ticks(3);
        chk("R6 count restarted", {31'b0, rd_data[3]}, 32'h0);
        give_ticks(1);
        chk("R6 flag after full interval", {31'b0, rd_data[3]}, 32'h1);

        // R8: set beats clear in the same cycle
        wr(32'hC9);
        give_ticks(3);
        wr_t(32'hC8, 1'b1);
        chk("R8 set wins over clear", {31'b0, rd_data[3]}, 32'h1);
        wr(32'hC8);
        chk("R8 clear", {31'b0, rd_data[3]}, 32'h0);

        // R7: interval change restarts, interrupt-enable change does not
        wr(32'hD9);
        give_ticks(10);
        wr(32'hC0);
        give_ticks(3);
        chk("R7 code change restarts", {31'b0, rd_data[3]}, 32'h0);
        give_ticks(1);
        chk("R7 new interval", {31'b0, rd_data[3]}, 32'h1);
        wr(32'h99);
        give_ticks(8);
        wr(32'hD0);
        give_ticks(7);
        chk("R7 ie change keeps count", {31'b0, rd_data[3]}, 32'h0);
        give_ticks(1);
        chk("R7 flag at original timeout", {31'b0, rd_data[3]}, 32'h1);

        // R10: stop holds everything, re-enable counts from zero
        base = rst_seen;
        wr(32'hCB);
        give_ticks(2);
        wr(32'h08);
        chk("R10 stopped", rd_data, 32'h0);
        give_ticks(50);
        chk("R10 no flag while stopped", rd_data, 32'h0);
        chk("R10 no irq while stopped", {31'b0, irq}, 32'h0);
        chk("R10 no request while stopped", rst_seen - base, 0);
        wr(32'h80);
        give_ticks(3);
        chk("R10 fresh count", {31'b0, rd_data[3]}, 32'h0);
        give_ticks(1);
        chk("R10 flag after re-enable", {31'b0, rd_data[3]}, 32'h1);
        wr(32'h08);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule